// File: doc/BRIEF.md
# WAV Header Prepender

This block places a complete PCM WAV file header at the head of a byte-wide audio stream and then hands the stream through untouched. It sits between an 8-bit sample source and the write side of a byte-wide output buffer. Both sides use a valid/ready handshake. A byte moves on any clock edge where valid and ready are both high.

After reset the block is quiet. It accepts no samples and presents nothing downstream. A one-cycle start pulse begins header emission. The 44 header bytes leave in file order, one for each accepted transfer. Every header field is worked out at elaboration time from four parameters: sample rate, channel count, bits per sample and declared data length. Multi-byte fields go out least-significant byte first. While the header is in flight the source is held off with back-pressure, so no sample is lost. Once the last header byte has been taken, the block becomes a combinational passthrough. It stays a passthrough until the next reset.

The declared data length is fixed ahead of time and defaults to 5510 bytes. It may be set larger than the number of bytes that actually follow.

Top module: `wav_hdr_prepend`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, snk_valid and src_ready are both 0.
- R2: Before a start pulse, src_valid and src_data have no effect: snk_valid stays 0 and src_ready stays 0.
- R3: After start, exactly 44 header bytes are offered before any sample byte. Bytes 0-3 are ASCII "RIFF", 8-11 are "WAVE", 12-15 are "fmt " (0x66 0x6D 0x74 0x20) and 36-39 are "data".
- R4: Every multi-byte field goes least-significant byte first. Bytes 4-7 carry DATA_BYTES+36 and bytes 40-43 carry DATA_BYTES. With the defaults, bytes 4-7 are 0xAA 0x15 0x00 0x00.
- R5: The format fields are laid out as follows. Bytes 16-19 hold 16. Bytes 20-21 hold 1 (PCM). Bytes 22-23 hold CHANNELS. Bytes 24-27 hold SAMPLE_RATE. Bytes 28-31 hold SAMPLE_RATE*CHANNELS*BITS_PER_SAMPLE/8. Bytes 32-33 hold CHANNELS*BITS_PER_SAMPLE/8. Bytes 34-35 hold BITS_PER_SAMPLE.
- R6: During the header, when snk_valid is 1 and snk_ready is 0, the same byte stays on snk_data with snk_valid held at 1 on the next cycle. The header index advances only on an accepted transfer.
- R7: Throughout header emission src_ready is 0, so a waiting sample is held off and not dropped.
- R8: After the 44th header byte is accepted, from the next cycle on, snk_valid equals src_valid, snk_data equals src_data and src_ready equals snk_ready, all in the same cycle.
- R9: A start pulse during the header or during passthrough has no effect: the header is not restarted and passthrough continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins header emission from idle |
| src_data | input | 8 | Sample byte from the source |
| src_valid | input | 1 | Source has a byte on src_data |
| src_ready | output | 1 | Block takes the source byte this cycle |
| snk_data | output | 8 | Byte offered to the output buffer |
| snk_valid | output | 1 | snk_data holds a byte |
| snk_ready | input | 1 | Output buffer accepts the byte this cycle |

## Verification
The bench stalls the output side in the middle of the header and on its last byte. A design that advanced its index without a handshake would skip or duplicate a header byte. The bench keeps a sample waiting on the source for the whole header. A design that leaked src_ready early would drop that sample or slip it in between header bytes. It checks the exact hand-over cycle after byte 43 and pulses start again during passthrough, which would expose an off-by-one header length or a header restart. It checks every field byte by byte against values built independently, which exposes a byte-order or byte-rate arithmetic slip.

// File: rtl/wav_hdr_pkg.sv
package wav_hdr_pkg;
  localparam int HDR_LEN = 44;
  localparam int IDX_W   = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PASS} wh_state_e;

  // One 32-bit little-endian word of the header; word index = byte index / 4.
  function automatic logic [31:0] hdr_word(input logic [3:0] wi,
                                           input logic [31:0] rate,
                                           input logic [15:0] chans,
                                           input logic [15:0] bits,
                                           input logic [31:0] len);
    logic [15:0] align;
    logic [31:0] brate;
    align = 16'((32'(chans) * 32'(bits)) >> 3);
    brate = rate * 32'(align);
    case (wi)
      4'd0:    hdr_word = 32'h4646_4952;          // "RIFF"
      4'd1:    hdr_word = len + 32'd36;
      4'd2:    hdr_word = 32'h4556_4157;          // "WAVE"
      4'd3:    hdr_word = 32'h2074_6D66;          // "fmt "
      4'd4:    hdr_word = 32'd16;
      4'd5:    hdr_word = {chans, 16'd1};
      4'd6:    hdr_word = rate;
      4'd7:    hdr_word = brate;
      4'd8:    hdr_word = {bits, align};
      4'd9:    hdr_word = 32'h6174_6164;          // "data"
      4'd10:   hdr_word = len;
      default: hdr_word = 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] idx,
                                          input logic [31:0] rate,
                                          input logic [15:0] chans,
                                          input logic [15:0] bits,
                                          input logic [31:0] len);
    logic [31:0] w;
    w = hdr_word(idx[5:2], rate, chans, bits, len);
    hdr_byte = w[8*idx[1:0] +: 8];
  endfunction
endpackage

// File: rtl/wav_hdr_rom.sv
module wav_hdr_rom
  import wav_hdr_pkg::*;
#(
  parameter int SAMPLE_RATE     = 8000,
  parameter int CHANNELS        = 1,
  parameter int BITS_PER_SAMPLE = 8,
  parameter int DATA_BYTES      = 5510
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       hdr_byte_o
);
  localparam logic [31:0] RATE_V = 32'(SAMPLE_RATE);
  localparam logic [15:0] CH_V   = 16'(CHANNELS);
  localparam logic [15:0] BITS_V = 16'(BITS_PER_SAMPLE);
  localparam logic [31:0] LEN_V  = 32'(DATA_BYTES);

  always_comb hdr_byte_o = hdr_byte(idx, RATE_V, CH_V, BITS_V, LEN_V);
endmodule

// File: rtl/wav_hdr_seq.sv
module wav_hdr_seq
  import wav_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             snk_ready,
  output logic [IDX_W-1:0] idx,
  output logic             idle_active,
  output logic             hdr_active,
  output logic             pass_active,
  output logic             hdr_last_fire
);
  wh_state_e state_q;
  logic      hdr_fire;

  assign idle_active   = (state_q == ST_IDLE);
  assign hdr_active    = (state_q == ST_HDR);
  assign pass_active   = (state_q == ST_PASS);
  assign hdr_fire      = hdr_active && snk_ready;
  assign hdr_last_fire = hdr_fire && (idx == IDX_W'(HDR_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_HDR;
          idx     <= '0;
        end
        ST_HDR: if (hdr_last_fire) begin
          state_q <= ST_PASS;
        end else if (hdr_fire) begin
          idx <= idx + 1'b1;
        end
        default: state_q <= ST_PASS;
      endcase
    end
  end
endmodule

// File: rtl/wav_hdr_mux.sv
module wav_hdr_mux (
  input  logic       hdr_active,
  input  logic       pass_active,
  input  logic [7:0] hdr_byte_i,
  input  logic [7:0] src_data,
  input  logic       src_valid,
  input  logic       snk_ready,
  output logic [7:0] snk_data,
  output logic       snk_valid,
  output logic       src_ready
);
  always_comb begin
    snk_data  = 8'h00;
    snk_valid = 1'b0;
    src_ready = 1'b0;
    if (hdr_active) begin
      snk_data  = hdr_byte_i;
      snk_valid = 1'b1;
    end else if (pass_active) begin
      snk_data  = src_data;
      snk_valid = src_valid;
      src_ready = snk_ready;
    end
  end
endmodule

// File: rtl/wav_hdr_prepend.sv
module wav_hdr_prepend
  import wav_hdr_pkg::*;
#(
  parameter int SAMPLE_RATE     = 8000,
  parameter int CHANNELS        = 1,
  parameter int BITS_PER_SAMPLE = 8,
  parameter int DATA_BYTES      = 5510
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] src_data,
  input  logic       src_valid,
  output logic       src_ready,
  output logic [7:0] snk_data,
  output logic       snk_valid,
  input  logic       snk_ready
);
  logic [IDX_W-1:0] hdr_idx;
  logic             idle_active, hdr_active, pass_active, hdr_last_fire;
  logic [7:0]       hdr_byte_w;

  wav_hdr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .snk_ready(snk_ready),
    .idx(hdr_idx), .idle_active(idle_active), .hdr_active(hdr_active),
    .pass_active(pass_active), .hdr_last_fire(hdr_last_fire)
  );

  wav_hdr_rom #(
    .SAMPLE_RATE(SAMPLE_RATE), .CHANNELS(CHANNELS),
    .BITS_PER_SAMPLE(BITS_PER_SAMPLE), .DATA_BYTES(DATA_BYTES)
  ) u_rom (
    .idx(hdr_idx), .hdr_byte_o(hdr_byte_w)
  );

  wav_hdr_mux u_mux (
    .hdr_active(hdr_active), .pass_active(pass_active),
    .hdr_byte_i(hdr_byte_w), .src_data(src_data), .src_valid(src_valid),
    .snk_ready(snk_ready), .snk_data(snk_data), .snk_valid(snk_valid),
    .src_ready(src_ready)
  );
endmodule

// File: rtl/wav_hdr_prepend_chk.sv
module wav_hdr_prepend_chk
  import wav_hdr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [7:0]       src_data,
  input logic             src_valid,
  input logic             src_ready,
  input logic [7:0]       snk_data,
  input logic             snk_valid,
  input logic             snk_ready,
  input logic [IDX_W-1:0] hdr_idx,
  input logic             idle_active,
  input logic             hdr_active,
  input logic             pass_active,
  input logic             hdr_last_fire
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!snk_valid && !src_ready));  // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle_active |-> (!snk_valid && !src_ready));  // R2

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_active |-> (hdr_idx < IDX_W'(HDR_LEN)));  // R3

  AST_HDR_TO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_last_fire |=> pass_active);  // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_active && snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data) && $stable(hdr_idx)));  // R6

  AST_HDR_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_active |-> (!src_ready && snk_valid));  // R7

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    pass_active |-> (snk_valid == src_valid && src_ready == snk_ready &&
                     (!src_valid || snk_data == src_data)));  // R8

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_active && start) |=> pass_active);  // R9

  AST_HDR_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_active && start && !snk_ready) |=> $stable(hdr_idx));  // R9
endmodule

bind wav_hdr_prepend wav_hdr_prepend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data),
  .src_valid(src_valid), .src_ready(src_ready), .snk_data(snk_data),
  .snk_valid(snk_valid), .snk_ready(snk_ready), .hdr_idx(hdr_idx),
  .idle_active(idle_active), .hdr_active(hdr_active),
  .pass_active(pass_active), .hdr_last_fire(hdr_last_fire)
);

// File: tb/test_wav_hdr_prepend.sv
`timescale 1ns/1ps
module test_wav_hdr_prepend;
  localparam int RATE = 8000;
  localparam int CH   = 1;
  localparam int BITS = 8;
  localparam int LEN  = 5510;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic       src_valid = 1'b0;
  logic       src_ready;
  logic [7:0] snk_data;
  logic       snk_valid;
  logic       snk_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_hdr [64];
  int hlen = 0;

  always #2.5 clk = ~clk;

  wav_hdr_prepend #(.SAMPLE_RATE(RATE), .CHANNELS(CH),
                    .BITS_PER_SAMPLE(BITS), .DATA_BYTES(LEN)) i_wav_hdr_prepend (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data),
    .src_valid(src_valid), .src_ready(src_ready), .snk_data(snk_data),
    .snk_valid(snk_valid), .snk_ready(snk_ready)
  );

  // Passthrough vectors: {src_data, src_valid, snk_ready, exp snk_valid, exp src_ready}
  localparam logic [11:0] VEC [8] = '{
    {8'h5A, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'hA5, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h80, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h7F, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h01, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hC3, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic put_tag(input string s);
    for (int k = 0; k < 4; k++) begin exp_hdr[hlen] = s[k]; hlen++; end
  endtask

  task automatic put_le(input longint v, input int nb);
    longint t = v;
    for (int k = 0; k < nb; k++) begin
      exp_hdr[hlen] = 8'(t % 256); t = t / 256; hlen++;
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    summary();
  end

  initial begin
    // Expected header, built field by field
    put_tag("RIFF"); put_le(LEN + 36, 4); put_tag("WAVE"); put_tag("fmt ");
    put_le(16, 4); put_le(1, 2); put_le(CH, 2); put_le(RATE, 4);
    put_le(RATE * CH * (BITS / 8), 4); put_le(CH * (BITS / 8), 2); put_le(BITS, 2);
    put_tag("data"); put_le(LEN, 4);

    @(negedge clk); @(negedge clk);
    #1;
    chk(!snk_valid && !src_ready, "R1 reset quiet", {snk_valid, src_ready}, 0);
    rst_n = 1'b1;
    src_valid = 1'b1; src_data = 8'h99; snk_ready = 1'b1;
    #1;
    chk(!snk_valid && !src_ready, "R1 first cycle after reset", {snk_valid, src_ready}, 0);
    for (int c = 0; c < 3; c++) begin
      step(); #1;
      chk(!snk_valid && !src_ready, "R2 idle ignores source", {snk_valid, src_ready}, 0);
    end

    // Start: a sample is kept waiting throughout the header
    start = 1'b1; step(); start = 1'b0;
    for (int i = 0; i < 44; i++) begin
      if (i == 7 || i == 21 || i == 43) begin
        snk_ready = 1'b0;
        if (i == 21) start = 1'b1;   // R9 start during header
        #1;
        chk(snk_valid && snk_data == exp_hdr[i], "R6 stalled byte", snk_data, exp_hdr[i]);
        step(); start = 1'b0;
        snk_ready = 1'b1;
      end
      #1;
      chk(snk_valid && snk_data == exp_hdr[i],
          (i < 4 || (i >= 8 && i < 16) || (i >= 36 && i < 40)) ? "R3 tag byte" :
          (i < 8 || i >= 40) ? "R4 length byte" : "R5 format byte",
          snk_data, exp_hdr[i]);
      chk(!src_ready, "R7 source held off", src_ready, 0);
      step();
    end

    // Hand-over cycle: the waiting sample 0x99 appears now
    #1;
    chk(snk_valid && snk_data == 8'h99 && src_ready, "R8 first pass byte", snk_data, 8'h99);

    for (int v = 0; v < 8; v++) begin
      src_data  = VEC[v][11:4];
      src_valid = VEC[v][3];
      snk_ready = VEC[v][2];
      #1;
      chk(snk_valid == VEC[v][1] && src_ready == VEC[v][0] &&
          (!VEC[v][1] || snk_data == VEC[v][11:4]), "R8 passthrough vector",
          {snk_data, snk_valid, src_ready}, {VEC[v][11:4], VEC[v][1:0]});
      step();
    end

    // R9: start in passthrough does not restart the header
    src_data = 8'h3C; src_valid = 1'b1; snk_ready = 1'b1; start = 1'b1;
    step(); start = 1'b0;
    #1;
    chk(snk_valid && snk_data == 8'h3C && src_ready, "R9 start ignored in pass", snk_data, 8'h3C);
    step(); #1;
    chk(snk_data == 8'h3C && src_ready, "R9 still passthrough", snk_data, 8'h3C);

    // Reset again: back to idle, source ignored
    rst_n = 1'b0; step(); #1;
    chk(!snk_valid && !src_ready, "R1 reset mid-stream", {snk_valid, src_ready}, 0);
    rst_n = 1'b1; step(); #1;
    chk(!snk_valid && !src_ready, "R2 idle after re-reset", {snk_valid, src_ready}, 0);

    // Second header with no stalls: first byte restarts at "R"
    start = 1'b1; step(); start = 1'b0; #1;
    chk(snk_valid && snk_data == 8'h52, "R3 header restarts after reset", snk_data, 8'h52);

    summary();
  end
endmodule